// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and inspects the byte stream handed to the client. Bytes arrive one per clock on an 8-bit bus qualified by a valid strobe. The first six bytes of every frame form the destination address. The block compares each address byte, as it arrives, against several candidates. The candidates are one unicast station address, the broadcast address and a table of multicast entries, four by default. It then reports whether the frame is for this station.

The unicast address and the promiscuous flag take their reset values from static configuration inputs. The multicast table has no preload: it starts empty and is filled through a single-cycle register-write host port. Any host write replaces the preloaded value. In promiscuous mode every frame is marked as passing, but the mismatch indication is still raised for frames whose address matched nothing.

Top module: `rxaf_top`

## Requirements
- R1: While `rstN` is low, the unicast address register loads `cfgUnicastAddr`. After reset, a frame whose destination equals that address passes.
- R2: While `rstN` is low, the promiscuous flag loads `cfgPromisc`. The multicast table is not loaded from any configuration input.
- R3: After reset, every multicast entry is invalid. An invalid entry never matches, including a destination of all zeros.
- R4: A host write with `hostWrEn` high stores `hostWrData` at `hostAddr` and overrides any preloaded value. The word addresses are:
  - 0: unicast bits [31:0]
  - 1: unicast bits [47:32], taken from data bits [15:0]
  - 2: mode, where data bit 31 is the promiscuous flag
  - 4+2k: multicast entry k, bits [31:0]
  - 5+2k: multicast entry k, bits [47:32]
- R5: The destination address is received most significant byte first. Byte 0 of the frame is address bits [47:40].
- R6: A frame of six or more bytes whose destination matches no valid candidate raises `frameDrop`. The pulse occurs in the cycle after the sixth byte is accepted.
- R7: The broadcast address FF-FF-FF-FF-FF-FF always matches.
- R8: Once either word of a multicast entry has been written, that entry is valid. A destination equal to a valid entry matches.
- R9: With the promiscuous flag set, `framePass` is raised for every frame of six or more bytes. `frameDrop` is still raised for frames that match nothing.
- R10: `framePass` rises in the cycle after the sixth byte when the address matches or the flag is set. It stays high while `rxValid` stays high, and clears on the first clock edge that samples `rxValid` low.
- R11: A low `rxValid` restarts byte counting. A frame shorter than six bytes produces neither output, and a following frame is evaluated from its own first byte.
- R12: `frameDrop` is a single-cycle pulse, raised at most once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset, loads the preloads |
| cfgUnicastAddr | input | 48 | Static unicast address preload |
| cfgPromisc | input | 1 | Static promiscuous flag preload |
| hostWrEn | input | 1 | Register write strobe |
| hostAddr | input | 4 | Register word address |
| hostWrData | input | 32 | Register write data |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| frameDrop | output | 1 | One-cycle mismatch pulse |
| framePass | output | 1 | Frame accepted, held to end of frame |

## Verification
The checker watches the output protocol on every cycle:
- `frameDrop` lasts one cycle and only follows accepted data.
- `framePass` holds through the frame and clears once `rxValid` falls.
- At the resolution cycle, `framePass` agrees with the promiscuous flag and the match result.

Only the bench's scenarios can show which addresses actually match. These cover the byte order, per-bit sensitivity of every candidate, the empty multicast table, preload versus host override, and the restart after short frames.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_BYTES  = 6;
  localparam int MAC_W       = BYTE_W * ADDR_BYTES;
  localparam int CNT_W       = $clog2(ADDR_BYTES + 1);
  localparam int HOST_DW     = 32;
  localparam int ADR_UC_LO   = 0;
  localparam int ADR_UC_HI   = 1;
  localparam int ADR_MODE    = 2;
  localparam int ADR_MC_BASE = 4;
  localparam int PROMISC_BIT = 31;

  typedef struct packed {
    logic             clear;
    logic             cmpEn;
    logic             first;
    logic             last;
    logic [CNT_W-1:0] byteIdx;
  } rxafStrobe_t;
endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
  import rxaf_pkg::*;
#(
  parameter int NUM_MCAST = 4,
  parameter int HOST_AW   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MAC_W-1:0]     cfgUnicastAddr,
  input  logic                 cfgPromisc,
  input  logic                 wrEn,
  input  logic [HOST_AW-1:0]   wrAddr,
  input  logic [HOST_DW-1:0]   wrData,
  output logic [MAC_W-1:0]     ucastAddr,
  output logic                 promisc,
  output logic [MAC_W-1:0]     mcastAddr [NUM_MCAST],
  output logic [NUM_MCAST-1:0] mcastValid
);
  localparam int HI_W = MAC_W - HOST_DW;
  localparam logic [HOST_AW-1:0] A_UC_LO = HOST_AW'(ADR_UC_LO);
  localparam logic [HOST_AW-1:0] A_UC_HI = HOST_AW'(ADR_UC_HI);
  localparam logic [HOST_AW-1:0] A_MODE  = HOST_AW'(ADR_MODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ucastAddr <= cfgUnicastAddr;
      promisc   <= cfgPromisc;
    end else if (wrEn) begin
      if (wrAddr == A_UC_LO) ucastAddr[HOST_DW-1:0]     <= wrData;
      if (wrAddr == A_UC_HI) ucastAddr[MAC_W-1:HOST_DW] <= wrData[HI_W-1:0];
      if (wrAddr == A_MODE)  promisc                    <= wrData[PROMISC_BIT];
    end
  end

  for (genvar k = 0; k < NUM_MCAST; k++) begin : gMcast
    localparam logic [HOST_AW-1:0] A_LO = HOST_AW'(ADR_MC_BASE + 2 * k);
    localparam logic [HOST_AW-1:0] A_HI = HOST_AW'(ADR_MC_BASE + 2 * k + 1);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mcastAddr[k]  <= '0;
        mcastValid[k] <= 1'b0;
      end else if (wrEn) begin
        if (wrAddr == A_LO) begin
          mcastAddr[k][HOST_DW-1:0] <= wrData;
          mcastValid[k]             <= 1'b1;
        end
        if (wrAddr == A_HI) begin
          mcastAddr[k][MAC_W-1:HOST_DW] <= wrData[HI_W-1:0];
          mcastValid[k]                 <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  output rxafStrobe_t strobe
);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !rxValid) byteCnt <= '0;
    else if (byteCnt < CNT_END) byteCnt <= byteCnt + 1'b1;
  end

  always_comb begin
    strobe.clear   = !rxValid;
    strobe.cmpEn   = rxValid && (byteCnt < CNT_END);
    strobe.first   = strobe.cmpEn && (byteCnt == '0);
    strobe.last    = strobe.cmpEn && (byteCnt == CNT_LAST);
    strobe.byteIdx = byteCnt;
  end
endmodule

// File: rtl/rxaf_dpath.sv
module rxaf_dpath
  import rxaf_pkg::*;
#(
  parameter int NUM_MCAST = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxafStrobe_t          strobe,
  input  logic [BYTE_W-1:0]    rxData,
  input  logic [MAC_W-1:0]     ucastAddr,
  input  logic                 promisc,
  input  logic [MAC_W-1:0]     mcastAddr [NUM_MCAST],
  input  logic [NUM_MCAST-1:0] mcastValid,
  output logic                 frameDrop,
  output logic                 framePass
);
  localparam int NUM_CAND = NUM_MCAST + 2;

  logic [MAC_W-1:0]    candAddr [NUM_CAND];
  logic [NUM_CAND-1:0] candValid;
  logic [NUM_CAND-1:0] byteHit;
  logic [NUM_CAND-1:0] runHit;
  logic                anyHit;
  int                  sel;

  always_comb begin
    candAddr[0]  = ucastAddr;
    candValid[0] = 1'b1;
    candAddr[1]  = '1;
    candValid[1] = 1'b1;
  end

  for (genvar k = 0; k < NUM_MCAST; k++) begin : gCand
    always_comb begin
      candAddr[k+2]  = mcastAddr[k];
      candValid[k+2] = mcastValid[k];
    end
  end

  always_comb begin
    if (int'(strobe.byteIdx) < ADDR_BYTES) sel = ADDR_BYTES - 1 - int'(strobe.byteIdx);
    else sel = 0;
  end

  for (genvar c = 0; c < NUM_CAND; c++) begin : gCmp
    logic [BYTE_W-1:0] candByte;
    always_comb begin
      candByte   = candAddr[c][sel*BYTE_W +: BYTE_W];
      byteHit[c] = candValid[c] && (rxData == candByte);
    end
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clear) runHit[c] <= 1'b0;
      else if (strobe.cmpEn)     runHit[c] <= strobe.first ? byteHit[c] : (runHit[c] & byteHit[c]);
    end
  end

  assign anyHit = |(runHit & byteHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameDrop <= 1'b0;
      framePass <= 1'b0;
    end else begin
      frameDrop <= strobe.last && !anyHit;
      if (strobe.clear)     framePass <= 1'b0;
      else if (strobe.last) framePass <= anyHit || promisc;
    end
  end
endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
  import rxaf_pkg::*;
#(
  parameter int NUM_MCAST = 4,
  parameter int HOST_AW   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [47:0]        cfgUnicastAddr,
  input  logic               cfgPromisc,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWrData,
  input  logic               rxValid,
  input  logic [7:0]         rxData,
  output logic               frameDrop,
  output logic               framePass
);
  rxafStrobe_t         strobe;
  logic [MAC_W-1:0]    ucastAddr;
  logic                promiscQ;
  logic [MAC_W-1:0]    mcastAddr [NUM_MCAST];
  logic [NUM_MCAST-1:0] mcastValid;

  rxaf_regs #(.NUM_MCAST(NUM_MCAST), .HOST_AW(HOST_AW)) u_regs (
    .clk(clk), .rstN(rstN), .cfgUnicastAddr(cfgUnicastAddr), .cfgPromisc(cfgPromisc),
    .wrEn(hostWrEn), .wrAddr(hostAddr), .wrData(hostWrData),
    .ucastAddr(ucastAddr), .promisc(promiscQ), .mcastAddr(mcastAddr), .mcastValid(mcastValid)
  );

  rxaf_ctrl u_ctrl (.clk(clk), .rstN(rstN), .rxValid(rxValid), .strobe(strobe));

  rxaf_dpath #(.NUM_MCAST(NUM_MCAST)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData),
    .ucastAddr(ucastAddr), .promisc(promiscQ), .mcastAddr(mcastAddr), .mcastValid(mcastValid),
    .frameDrop(frameDrop), .framePass(framePass)
  );
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic frameDrop,
  input logic framePass,
  input logic promisc
);
  AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rstN) frameDrop |=> !frameDrop); // R12
  AST_DROP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN) frameDrop |-> $past(rxValid)); // R6
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rstN) (framePass && rxValid) |=> framePass); // R10
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN) !$past(rxValid) |-> (!framePass && !frameDrop)); // R11
  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rstN) frameDrop |-> (framePass == $past(promisc))); // R9
endmodule

bind rxaf_top rxaf_checker u_rxafChecker (
  .clk(clk), .rstN(rstN), .rxValid(rxValid),
  .frameDrop(frameDrop), .framePass(framePass), .promisc(promiscQ)
);

// File: tb/test_rxaf_top.sv
module test_rxaf_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] cfgUnicastAddr = 48'h0200_1122_3344;
  logic        cfgPromisc = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        frameDrop, framePass;

  int errors = 0;
  int checks = 0;

  logic [47:0] mUc;
  logic        mProm;
  logic [47:0] mMc [4];
  logic [3:0]  mMcV;

  always #5 clk = ~clk;

  rxaf_top i_rxaf_top (
    .clk(clk), .rstN(rstN), .cfgUnicastAddr(cfgUnicastAddr), .cfgPromisc(cfgPromisc),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .rxValid(rxValid), .rxData(rxData), .frameDrop(frameDrop), .framePass(framePass)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit modelMatch(input logic [47:0] da);
    bit m = (da == mUc) || (da == 48'hFFFF_FFFF_FFFF);
    for (int k = 0; k < 4; k++) if (mMcV[k] && da == mMc[k]) m = 1;
    return m;
  endfunction

  task automatic doReset(input logic [47:0] uc, input logic prom);
    @(negedge clk);
    rstN = 1'b0; cfgUnicastAddr = uc; cfgPromisc = prom; rxValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mUc = uc; mProm = prom; mMcV = '0;
    for (int k = 0; k < 4; k++) mMc[k] = '0;
  endtask

  task automatic hostWrite(input int adr, input logic [31:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 4'(adr); hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (adr == 0) mUc[31:0] = data;
    else if (adr == 1) mUc[47:32] = data[15:0];
    else if (adr == 2) mProm = data[31];
    else if (adr >= 4 && adr < 12) begin
      if (adr % 2 == 0) mMc[(adr-4)/2][31:0] = data;
      else mMc[(adr-4)/2][47:32] = data[15:0];
      mMcV[(adr-4)/2] = 1'b1;
    end
  endtask

  // Sends one frame; when tail is set it also checks the outputs after rxValid drops.
  task automatic sendFrame(input logic [47:0] da, input int len, input string req, input bit tail);
    bit expM = modelMatch(da);
    bit expPass = (expM || mProm) && (len >= 6);
    int drops = 0;
    bit passAt = 0;
    bit passBad = 0;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (frameDrop) drops++;
      if (i == 6) passAt = framePass;
      if (i < 6 && framePass) passBad = 1;
      if (i > 6 && framePass !== expPass) passBad = 1;
      if (i < len) begin
        rxValid = 1'b1;
        rxData = (i < 6) ? da[47-8*i -: 8] : 8'(i * 37);
      end else begin
        rxValid = 1'b0;
        rxData = '0;
      end
    end
    check(drops == ((len >= 6 && !expM) ? 1 : 0), req, "drop pulse count", drops, (len >= 6 && !expM));
    if (len >= 6) check(passAt == expPass, req, "pass at resolve", passAt, expPass);
    check(!passBad, req, "pass held over frame (R10)", passBad, 0);
    if (tail) begin
      @(negedge clk);
      check(!framePass && !frameDrop, req, "outputs clear after frame (R10)", {framePass, frameDrop}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] mcv [4];
    mcv[0] = 48'h0100_5E00_0010; mcv[1] = 48'h0100_5E7F_0001;
    mcv[2] = 48'h3333_0000_0002; mcv[3] = 48'h0180_C200_0021;

    doReset(48'h0200_1122_3344, 1'b0);
    @(negedge clk);
    check(!frameDrop && !framePass, "R1", "reset outputs", {frameDrop, framePass}, 0);

    sendFrame(48'h0200_1122_3344, 10, "R1", 1);
    sendFrame(48'h4433_2211_0002, 10, "R5", 1);   // byte-reversed unicast must fail
    sendFrame(48'h0, 8, "R3", 1);                // empty table never matches zero
    sendFrame(mcv[0], 8, "R3", 1);
    sendFrame(48'hFFFF_FFFF_FFFF, 9, "R7", 1);
    sendFrame(48'hFFFF_FFFF_FFFE, 9, "R7", 1);

    // R6: every single-bit corruption of the unicast address drops
    for (int b = 0; b < 48; b++) sendFrame(mUc ^ (48'd1 << b), 7, "R6", 0);

    // R8: fill the multicast table and sweep each entry
    for (int k = 0; k < 4; k++) begin
      hostWrite(4 + 2*k, mcv[k][31:0]);
      hostWrite(5 + 2*k, {16'h0, mcv[k][47:32]});
    end
    for (int k = 0; k < 4; k++) begin
      sendFrame(mcv[k], 8, "R8", 1);
      for (int b = 0; b < 48; b += 3) sendFrame(mcv[k] ^ (48'd1 << b), 6, "R8", 0);
    end

    // R4: host overrides the preloaded unicast address
    hostWrite(0, 32'hDEAD_BEEF);
    hostWrite(1, 32'h0000_0A0B);
    sendFrame(48'h0200_1122_3344, 8, "R4", 1);
    sendFrame(48'h0A0B_DEAD_BEEF, 8, "R4", 1);

    // R9: promiscuous via host
    hostWrite(2, 32'h8000_0000);
    sendFrame(48'h1234_5678_9ABC, 12, "R9", 1);
    sendFrame(48'h0A0B_DEAD_BEEF, 12, "R9", 1);
    hostWrite(2, 32'h7FFF_FFFF);
    sendFrame(48'h1234_5678_9ABC, 12, "R9", 1);

    // R10: long frame holds pass
    sendFrame(mcv[2], 40, "R10", 1);

    // R11: short frames and restart
    sendFrame(48'h0A0B_DEAD_BEEF, 4, "R11", 0);
    sendFrame(48'h1111_1111_1111, 5, "R11", 0);
    sendFrame(48'h0A0B_DEAD_BEEF, 7, "R11", 0);
    sendFrame(48'h1111_1111_1111, 7, "R12", 0);
    sendFrame(48'h1111_1111_1111, 20, "R12", 1);

    // R2: second reset with promiscuous preload; table empties again
    doReset(48'h0022_4466_88AA, 1'b1);
    sendFrame(48'h0022_4466_88AA, 8, "R2", 1);
    sendFrame(mcv[1], 8, "R2", 1);
    sendFrame(48'h0, 8, "R3", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule